// File: doc/BRIEF.md
# Converter Bus Interface Controller

This block is the digital front of an 8-bit converter whose conversion runs on its own internal timing. It accepts active-low chip-select and read strobes, a shared write/ready pin and a mode strap from a host bus. It starts conversions in an external conversion core and latches the result: eight data bits plus an overflow bit. It also flags the end of each conversion. The data outputs are given with an enable, so a pad ring can build a three-state bus from them.

When the strap is high, the block runs in write-read mode. A falling write edge starts a conversion, and a later read strobe fetches the result. When the strap is low, it runs in read mode. Here the read strobe itself starts the conversion, and the shared pin becomes an open-drain ready signal that holds the bus cycle until the new result is in the latch. Tying chip select and read low in write-read mode gives standalone use. In that case the outputs stay enabled and follow every write-started conversion.

All strobes pass through two synchronising flops before edge detection. A start request is refused while a conversion is pending and for `RECOVER_CYCLES` clocks after one completes.

Top module: `adc_bus_ctrl`

## Requirements
- R1: With `mode` high and `cs_n` low, a falling edge on `wrrdy_i` gives exactly one single-cycle `conv_start_o` pulse, whatever the width of the low pulse.
- R2: With `mode` low and `cs_n` low, a falling edge on `rd_n` gives one `conv_start_o` pulse. `rdy_pd_o` is 1 (pin pulled low) from then until the cycle after `conv_done_i`, and is 0 after that.
- R3: `eoc_n_o` is 1 after reset. It goes to 0 in the cycle after a `conv_done_i` that ends a pending conversion. It returns to 1 after a rising edge of `rd_n` with `cs_n` low, or when a new start is accepted.
- R4: `data_oe_o` is 1 only while both `cs_n` and `rd_n` (each two clocks behind) are low.
- R5: While `cs_n` is high, edges on `rd_n` and `wrrdy_i` start nothing and leave `eoc_n_o` and the latched result unchanged.
- R6: In read mode, `data_o` shows the previous result during the conversion. All bits of `data_o` and `ovf_o` take the new value in the same cycle, one clock after `conv_done_i`.
- R7: `data_o` (bits 7..0 of the result) and `ovf_o` (bit 8) hold their value until a new conversion completes, whatever `conv_result_i` does in the meantime.
- R8: With `mode` high and `cs_n` and `rd_n` held low, `data_oe_o` stays 1 throughout, and `data_o` updates after each write-started conversion.
- R9: A start request that arrives while a conversion is pending, or within `RECOVER_CYCLES` clocks after completion, is ignored. One that arrives after the window is accepted.
- R10: In write-read mode, a read strobe starts no conversion and `rdy_pd_o` stays 0.
- R11: After reset, `data_o` = 0, `ovf_o` = 0, `data_oe_o` = 0, `rdy_pd_o` = 0 and no start has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wrrdy_i | input | 1 | Level seen on the shared write/ready pin |
| mode | input | 1 | 1 = write-read mode, 0 = read mode |
| conv_done_i | input | 1 | Completion pulse from the conversion core |
| conv_result_i | input | DATA_W+1 | Result from the core; MSB is overflow |
| conv_start_o | output | 1 | Single-cycle start pulse to the core |
| rdy_pd_o | output | 1 | Pull-down enable for the shared pin in read mode |
| eoc_n_o | output | 1 | End-of-conversion flag, active low |
| ovf_o | output | 1 | Latched overflow bit |
| data_oe_o | output | 1 | Output enable for the data bus |
| data_o | output | DATA_W | Latched conversion result |

## Verification
The bench goes after the cycles around completion in read mode, where a design that loads the latch early or in pieces shows the new value during the conversion or a mix of old and new bits. It sends second write edges into a busy conversion and just after completion. A design without the pending or recovery guard issues extra start pulses there, and these are counted at the core model. Long write pulses, read strobes in write-read mode and strobes with chip select high check that no spurious start appears and that the flag and latch are not disturbed. A standalone run watches the output enable every cycle, so a design that drops the enable while converting fails.

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int DATA_W         = 8,
  parameter int RECOVER_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wrrdy_i,
  input  logic              mode,
  input  logic              conv_done_i,
  input  logic [DATA_W:0]   conv_result_i,
  output logic              conv_start_o,
  output logic              rdy_pd_o,
  output logic              eoc_n_o,
  output logic              ovf_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int RW = $clog2(RECOVER_CYCLES + 2);

  logic [1:0]    cs_q, mode_q;
  logic [2:0]    rd_q, wr_q;
  logic          busy;
  logic [RW-1:0] rec_cnt;
  logic [DATA_W:0] result_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q   <= '1;
      mode_q <= '0;
      rd_q   <= '1;
      wr_q   <= '1;
    end else begin
      cs_q   <= {cs_q[0], cs_n};
      mode_q <= {mode_q[0], mode};
      rd_q   <= {rd_q[1:0], rd_n};
      wr_q   <= {wr_q[1:0], wrrdy_i};
    end

  wire sel      = ~cs_q[1];
  wire wr_mode  = mode_q[1];
  wire rd_fall  = rd_q[2] & ~rd_q[1];
  wire rd_rise  = ~rd_q[2] & rd_q[1];
  wire wr_fall  = wr_q[2] & ~wr_q[1];
  wire start_rq = sel & (wr_mode ? wr_fall : rd_fall);
  wire idle     = ~busy & (rec_cnt == '0);
  wire landed   = busy & conv_done_i;

  assign conv_start_o = start_rq & idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      rec_cnt  <= '0;
      result_q <= '0;
      eoc_n_o  <= 1'b1;
    end else begin
      if (conv_start_o)
        busy <= 1'b1;
      else if (landed)
        busy <= 1'b0;

      if (landed)
        rec_cnt <= RW'(RECOVER_CYCLES);
      else if (rec_cnt != '0)
        rec_cnt <= rec_cnt - 1'b1;

      if (landed)
        result_q <= conv_result_i;

      if (landed)
        eoc_n_o <= 1'b0;
      else if (conv_start_o || (sel && rd_rise))
        eoc_n_o <= 1'b1;
    end

  assign rdy_pd_o  = busy & ~wr_mode;
  assign data_oe_o = ~cs_q[1] & ~rd_q[1];
  assign data_o    = result_q[DATA_W-1:0];
  assign ovf_o     = result_q[DATA_W];

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int DATA_W         = 8,
  parameter int RECOVER_CYCLES = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              mode,
  input logic              conv_start_o,
  input logic              conv_done_i,
  input logic              rdy_pd_o,
  input logic              eoc_n_o,
  input logic              ovf_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o
);

  logic pend;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            pend <= 1'b0;
    else if (conv_start_o) pend <= 1'b1;
    else if (conv_done_i)  pend <= 1'b0;

  assert_single_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);

  assert_ready_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_pd_o) |-> $past(conv_done_i));

  assert_eoc_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n_o) |-> $past(conv_done_i));

  assert_oe_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (!$past(cs_n, 2) && !$past(rd_n, 2)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done_i |=> $stable({ovf_o, data_o}));

  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> !pend);

  generate
    if (RECOVER_CYCLES > 0) begin : g_rec
      assert_no_start_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && pend) |=> !conv_start_o);
    end
  endgenerate

  assert_pd_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pd_o |-> !$past(mode, 2));

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.DATA_W(DATA_W), .RECOVER_CYCLES(RECOVER_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .mode(mode),
  .conv_start_o(conv_start_o), .conv_done_i(conv_done_i), .rdy_pd_o(rdy_pd_o),
  .eoc_n_o(eoc_n_o), .ovf_o(ovf_o), .data_oe_o(data_oe_o), .data_o(data_o)
);

// File: tb/tb_adc_bus_ctrl.sv
`timescale 1ns/1ps
module tb_adc_bus_ctrl;
  localparam int RECOV = 6;
  localparam int LAT   = 16;
  localparam int NV    = 6;
  // {mode, ovf, data}
  localparam logic [9:0] VEC [NV] = '{10'h2A5, 10'h03C, 10'h3FF, 10'h000, 10'h281, 10'h15A};

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_drv = 1, mode = 1;
  logic [8:0] sample = '0;
  logic conv_start_o, rdy_pd_o, eoc_n_o, ovf_o, data_oe_o, conv_done_i;
  logic [7:0] data_o;
  int cnt, starts, checks = 0, errors = 0;

  always #4 clk = ~clk;

  wire wr_pin = mode ? wr_drv : ~rdy_pd_o;

  adc_bus_ctrl #(.DATA_W(8), .RECOVER_CYCLES(RECOV)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wrrdy_i(wr_pin), .mode(mode),
    .conv_done_i(conv_done_i), .conv_result_i(sample), .conv_start_o(conv_start_o),
    .rdy_pd_o(rdy_pd_o), .eoc_n_o(eoc_n_o), .ovf_o(ovf_o), .data_oe_o(data_oe_o), .data_o(data_o));

  always @(posedge clk)
    if (!rst_n) begin cnt <= 0; starts <= 0; end
    else if (conv_start_o) begin cnt <= LAT; starts <= starts + 1; end
    else if (cnt != 0) cnt <= cnt - 1;
  assign conv_done_i = (cnt == 1);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_pulse(input int w);
    wr_drv = 0; tick(w); wr_drv = 1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!conv_done_i && n < 200) begin @(negedge clk); n++; end
    chk("R2 done seen", conv_done_i, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] prev;
    int s0, bad;
    tick(3); rst_n = 1; tick(2);
    chk("R11 data", data_o, 0);
    chk("R11 ovf", ovf_o, 0);
    chk("R11 oe", data_oe_o, 0);
    chk("R11 pd", rdy_pd_o, 0);
    chk("R11 starts", starts, 0);
    chk("R3 eoc reset", eoc_n_o, 1);
    prev = '0;

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][9]; sample = VEC[i][8:0]; tick(4);
      s0 = starts;
      if (mode) begin
        cs_n = 0; wr_pulse(1 + i); tick(4);
        chk("R1 one start", starts, s0 + 1);
        chk("R10 no pulldown", rdy_pd_o, 0);
        wait_done(); tick(1);
        chk("R3 eoc low", eoc_n_o, 0);
        rd_n = 0; tick(3);
        chk("R4 oe on", data_oe_o, 1);
        chk("R1 data", data_o, sample[7:0]);
        chk("R1 ovf", ovf_o, sample[8]);
        rd_n = 1; tick(4);
        chk("R3 eoc cleared", eoc_n_o, 1);
        chk("R4 oe off", data_oe_o, 0);
        chk("R10 read no start", starts, s0 + 1);
      end else begin
        cs_n = 0; rd_n = 0; tick(3);
        chk("R2 pulldown on", rdy_pd_o, 1);
        chk("R2 start", starts, s0 + 1);
        chk("R6 oe", data_oe_o, 1);
        chk("R6 prev data", {ovf_o, data_o}, prev);
        wait_done();
        chk("R6 prev at done", {ovf_o, data_o}, prev);
        tick(1);
        chk("R6 new data", {ovf_o, data_o}, sample);
        chk("R2 pulldown off", rdy_pd_o, 0);
        chk("R3 eoc low", eoc_n_o, 0);
        rd_n = 1; tick(4);
        chk("R3 eoc cleared", eoc_n_o, 1);
      end
      cs_n = 1; prev = sample; tick(RECOV + 4);
    end

    // R5: chip select high
    mode = 1; tick(4); s0 = starts;
    wr_pulse(2); tick(6);
    chk("R5 no start", starts, s0);
    rd_n = 0; tick(3);
    chk("R5 oe off", data_oe_o, 0);
    rd_n = 1; tick(4);
    chk("R5 eoc kept", eoc_n_o, 1);
    chk("R5 data kept", {ovf_o, data_o}, prev);

    // R9: busy and recovery
    cs_n = 0; sample = 9'h0C3; s0 = starts;
    wr_pulse(1); tick(5); wr_pulse(1); tick(5);
    chk("R9 busy ignored", starts, s0 + 1);
    wait_done(); tick(1);
    wr_pulse(1); tick(3);
    chk("R9 recovery ignored", starts, s0 + 1);
    tick(RECOV + 2);
    sample = 9'h13E;
    wr_pulse(1); tick(4);
    chk("R9 accepted after", starts, s0 + 2);
    chk("R3 start clears eoc", eoc_n_o, 1);
    wait_done(); tick(1);
    rd_n = 0; tick(3);
    chk("R9 data", {ovf_o, data_o}, 9'h13E);

    // R7: hold indefinitely
    sample = 9'h055; tick(300);
    chk("R7 held", {ovf_o, data_o}, 9'h13E);
    rd_n = 1; tick(RECOV + 4);

    // R8: standalone
    rd_n = 0; tick(4);
    for (int k = 0; k < 2; k++) begin
      sample = (k == 0) ? 9'h1A0 : 9'h00F;
      bad = 0;
      wr_pulse(1);
      for (int c = 0; c < LAT + 4; c++) begin
        if (!data_oe_o) bad++;
        tick(1);
      end
      chk("R8 oe always", bad, 0);
      chk("R8 data", {ovf_o, data_o}, sample);
      chk("R3 eoc standalone", eoc_n_o, 0);
      tick(RECOV + 4);
    end
    rd_n = 1; cs_n = 1; tick(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule